// File: doc/BRIEF.md
# Settable Time-of-Day Counter

This block keeps the time of day as six BCD digits: hours, minutes and seconds, each a tens/units pair. It runs on one system clock and advances on a single-cycle 1 Hz tick enable that an upstream prescaler derives from a 32.768 kHz reference. In run mode the seconds pair counts ticks and passes its wrap on to the minutes pair, which passes its wrap on to the hours pair. The hours pair counts 00 to 23.

A small mode state machine has two states, `MODE_RUN` and `MODE_SET`. It moves from `MODE_RUN` to `MODE_SET` one clock after `set_mode` goes high, and from `MODE_SET` back to `MODE_RUN` one clock after `set_mode` goes low. In `MODE_SET` the seconds are frozen and ticks are ignored. The minutes pair is then fed by the rising edges of `min_set` and the hours pair by the rising edges of `hr_set`, not by the carry chain. A minutes wrap made while setting never reaches the hours.

A synchronous reset clears every digit and returns the state machine to `MODE_RUN`.

Top module: `tod_clock_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, all six digit outputs become 0 after that edge.
- R2: In run mode each tick advances the seconds by one. The units digit counts 0 to 9, and the tens digit counts 0 to 5, stepping when the units digit wraps. Seconds 59 goes to 00 on a tick.
- R3: In run mode the minutes advance by one exactly on the tick where seconds go from 59 to 00, using the same 0–9 units and 0–5 tens ranges.
- R4: In run mode the hours advance by one on the tick where the time goes from mm:ss 59:59 to 00:00. Hours units count 0 to 9 and hours tens count 0 to 2, so 09 goes to 10 and 23 goes to 00.
- R5: A tick at 23:59:59 in run mode gives 00:00:00 after that same clock edge.
- R6: `set_mode` high selects setting mode one clock later. In setting mode ticks leave all digits unchanged.
- R7: In setting mode each rising edge of `min_set` adds exactly one to the minutes, however long the input stays high. Minutes 59 goes to 00 and the hours stay unchanged.
- R8: In setting mode each rising edge of `hr_set` adds exactly one to the hours. Hours 23 goes to 00 and the minutes and seconds stay unchanged.
- R9: In run mode `min_set` and `hr_set` have no effect on any digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous global reset, active high |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| set_mode | input | 1 | 1 = setting mode, 0 = run mode |
| min_set | input | 1 | Minutes advance button (level, edge-detected) |
| hr_set | input | 1 | Hours advance button (level, edge-detected) |
| sec_units | output | 4 | Seconds units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD |
| min_units | output | 4 | Minutes units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD |
| hr_units | output | 4 | Hours units digit, BCD |
| hr_tens | output | 4 | Hours tens digit, BCD |

## Verification
The counter is driven with four kinds of input pattern:
- Plain runs of ticks exercise the seconds units/tens step and the 59-to-00 seconds wrap.
- Runs that start from times loaded through setting mode reach the rare boundaries: 09:59:59 separates a units wrap from a tens step in the hours, and 23:59:59 separates the full single-edge roll from a carry that ripples over several cycles.
- Long button holds in setting mode distinguish an edge detector from a level input, and the 59-to-00 minute wrap while setting shows whether a carry leaks into the hours.
- Button presses in run mode, and ticks in setting mode, confirm that the inactive inputs are ignored.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t tens;
        bcd_t units;
    } bcd_pair_t;

    typedef enum logic {
        MODE_RUN = 1'b0,
        MODE_SET = 1'b1
    } mode_e;
endpackage

// File: rtl/tod_edge_det.sv
module tod_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic pulse
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign pulse = lvl & ~lvl_q;

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
endmodule

// File: rtl/tod_digit_pair.sv
module tod_digit_pair
    import tod_pkg::*;
#(
    parameter int UNITS_MOD  = 10,
    parameter int TENS_MOD   = 6,
    parameter int WRAP_UNITS = UNITS_MOD - 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      inc,
    output bcd_pair_t val,
    output logic      at_wrap
);
    localparam bcd_t U_MAX  = bcd_t'(UNITS_MOD - 1);
    localparam bcd_t T_MAX  = bcd_t'(TENS_MOD - 1);
    localparam bcd_t U_WRAP = bcd_t'(WRAP_UNITS);

    bcd_pair_t val_q, val_d;

    assign at_wrap = (val_q.tens == T_MAX) && (val_q.units == U_WRAP);

    always_comb begin
        val_d = val_q;
        if (inc) begin
            if (at_wrap) begin
                val_d = '0;
            end else if (val_q.units == U_MAX) begin
                val_d.units = '0;
                val_d.tens  = val_q.tens + bcd_t'(1);
            end else begin
                val_d.units = val_q.units + bcd_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) val_q <= '0;
        else     val_q <= val_d;
    end

    assign val = val_q;

    // R2
    units_range_chk: assert property (@(posedge clk) disable iff (rst)
        val_q.units <= U_MAX);
    // R4
    tens_range_chk: assert property (@(posedge clk) disable iff (rst)
        val_q.tens <= T_MAX);
    // R4
    top_units_chk: assert property (@(posedge clk) disable iff (rst)
        (val_q.tens == T_MAX) |-> (val_q.units <= U_WRAP));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(val_q));
endmodule

// File: rtl/tod_mode_ctrl.sv
module tod_mode_ctrl
    import tod_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  set_req,
    input  logic  tick,
    input  logic  sec_wrap,
    input  logic  min_wrap,
    input  logic  min_pulse,
    input  logic  hr_pulse,
    output mode_e mode,
    output logic  sec_inc,
    output logic  min_inc,
    output logic  hr_inc
);
    mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_RUN: if (set_req)  state_d = MODE_SET;
            MODE_SET: if (!set_req) state_d = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= MODE_RUN;
        else     state_q <= state_d;
    end

    always_comb begin
        sec_inc = 1'b0;
        min_inc = 1'b0;
        hr_inc  = 1'b0;
        unique case (state_q)
            MODE_RUN: begin
                sec_inc = tick;
                min_inc = tick & sec_wrap;
                hr_inc  = tick & sec_wrap & min_wrap;
            end
            MODE_SET: begin
                min_inc = min_pulse;
                hr_inc  = hr_pulse;
            end
        endcase
    end

    assign mode = state_q;

    // R6
    enter_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_req |=> (state_q == MODE_SET));
    // R6
    leave_set_chk: assert property (@(posedge clk) disable iff (rst)
        !set_req |=> (state_q == MODE_RUN));
endmodule

// File: rtl/tod_clock_top.sv
module tod_clock_top
    import tod_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_1hz,
    input  logic       set_mode,
    input  logic       min_set,
    input  logic       hr_set,
    output logic [3:0] sec_units,
    output logic [3:0] sec_tens,
    output logic [3:0] min_units,
    output logic [3:0] min_tens,
    output logic [3:0] hr_units,
    output logic [3:0] hr_tens
);
    localparam int N_BTN = 2;

    logic [N_BTN-1:0] btn_lvl, btn_pulse;
    assign btn_lvl = {hr_set, min_set};

    for (genvar g = 0; g < N_BTN; g++) begin : g_btn
        tod_edge_det u_edge (
            .clk  (clk),
            .rst  (rst),
            .lvl  (btn_lvl[g]),
            .pulse(btn_pulse[g])
        );
    end

    mode_e     mode;
    logic      sec_inc, min_inc, hr_inc;
    logic      sec_wrap, min_wrap, hr_wrap;
    bcd_pair_t sec_v, min_v, hr_v;

    tod_mode_ctrl u_mode (
        .clk      (clk),
        .rst      (rst),
        .set_req  (set_mode),
        .tick     (tick_1hz),
        .sec_wrap (sec_wrap),
        .min_wrap (min_wrap),
        .min_pulse(btn_pulse[0]),
        .hr_pulse (btn_pulse[1]),
        .mode     (mode),
        .sec_inc  (sec_inc),
        .min_inc  (min_inc),
        .hr_inc   (hr_inc)
    );

    tod_digit_pair #(.UNITS_MOD(10), .TENS_MOD(6), .WRAP_UNITS(9)) u_sec (
        .clk(clk), .rst(rst), .inc(sec_inc), .val(sec_v), .at_wrap(sec_wrap)
    );

    tod_digit_pair #(.UNITS_MOD(10), .TENS_MOD(6), .WRAP_UNITS(9)) u_min (
        .clk(clk), .rst(rst), .inc(min_inc), .val(min_v), .at_wrap(min_wrap)
    );

    tod_digit_pair #(.UNITS_MOD(10), .TENS_MOD(3), .WRAP_UNITS(3)) u_hr (
        .clk(clk), .rst(rst), .inc(hr_inc), .val(hr_v), .at_wrap(hr_wrap)
    );

    assign sec_units = sec_v.units;
    assign sec_tens  = sec_v.tens;
    assign min_units = min_v.units;
    assign min_tens  = min_v.tens;
    assign hr_units  = hr_v.units;
    assign hr_tens   = hr_v.tens;

    // R5
    full_roll_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN && tick_1hz && sec_wrap && min_wrap && hr_wrap)
        |=> (sec_v == '0 && min_v == '0 && hr_v == '0));
    // R6
    set_sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SET) |=> $stable(sec_v));
    // R7
    set_hr_isolate_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SET && !btn_pulse[1]) |=> $stable(hr_v));
    // R9
    run_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN && !tick_1hz) |=> $stable({hr_v, min_v, sec_v}));
endmodule

// File: tb/tod_clock_top_tb_top.sv
module tod_clock_top_tb_top;
    logic clk = 1'b0;
    logic rst, tick_1hz, set_mode, min_set, hr_set;
    logic [3:0] sec_units, sec_tens, min_units, min_tens, hr_units, hr_tens;

    int checks = 0;
    int fails  = 0;
    int eh = 0, em = 0, es = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tod_clock_top dut_i (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .set_mode(set_mode),
        .min_set(min_set), .hr_set(hr_set),
        .sec_units(sec_units), .sec_tens(sec_tens),
        .min_units(min_units), .min_tens(min_tens),
        .hr_units(hr_units), .hr_tens(hr_tens)
    );

    function automatic logic [23:0] pack_time(int h, int m, int s);
        return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10),
                4'(s / 10), 4'(s % 10)};
    endfunction

    task automatic check_time(string tag);
        logic [23:0] got, exp;
        got = {hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units};
        exp = pack_time(eh, em, es);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one tick, model advances only in run mode
    task automatic do_tick(bit running);
        @(negedge clk) tick_1hz = 1'b1;
        @(negedge clk) tick_1hz = 1'b0;
        if (running) begin
            es++;
            if (es == 60) begin
                es = 0; em++;
                if (em == 60) begin
                    em = 0; eh = (eh + 1) % 24;
                end
            end
        end
    endtask

    task automatic press(bit is_hr, int hold, bit setting);
        @(negedge clk);
        if (is_hr) hr_set = 1'b1; else min_set = 1'b1;
        repeat (hold) @(negedge clk);
        hr_set = 1'b0; min_set = 1'b0;
        @(negedge clk);
        if (setting) begin
            if (is_hr) eh = (eh + 1) % 24;
            else       em = (em + 1) % 60;
        end
    endtask

    task automatic go_mode(bit s);
        @(negedge clk) set_mode = s;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        eh = 0; em = 0; es = 0;
        @(negedge clk);
        check_time("R1 reset");
    endtask

    task automatic t_seconds();
        for (int i = 0; i < 9; i++) do_tick(1'b1);
        check_time("R2 units 9");
        do_tick(1'b1);
        check_time("R2 tens step");
        for (int i = 0; i < 50; i++) do_tick(1'b1);
        check_time("R3 minute carry");
    endtask

    task automatic t_run_buttons();
        press(1'b0, 2, 1'b0);
        press(1'b1, 2, 1'b0);
        check_time("R9 run buttons ignored");
    endtask

    task automatic t_set_hold();
        go_mode(1'b1);
        for (int i = 0; i < 5; i++) do_tick(1'b0);
        check_time("R6 ticks ignored");
    endtask

    task automatic t_set_minutes();
        press(1'b0, 6, 1'b1);
        check_time("R7 one step per hold");
        while (em != 59) press(1'b0, 1, 1'b1);
        check_time("R7 minutes 59");
        press(1'b0, 1, 1'b1);
        check_time("R7 wrap no hour carry");
    endtask

    task automatic t_set_hours();
        while (eh != 23) press(1'b1, 1, 1'b1);
        check_time("R8 hours 23");
        press(1'b1, 4, 1'b1);
        check_time("R8 hours wrap");
    endtask

    task automatic t_full_roll();
        while (eh != 23) press(1'b1, 1, 1'b1);
        while (em != 59) press(1'b0, 1, 1'b1);
        go_mode(1'b0);
        while (es != 59) do_tick(1'b1);
        check_time("R5 at 23:59:59");
        do_tick(1'b1);
        check_time("R5 full roll");
    endtask

    task automatic t_hour_tens();
        go_mode(1'b1);
        while (eh != 9) press(1'b1, 1, 1'b1);
        while (em != 59) press(1'b0, 1, 1'b1);
        go_mode(1'b0);
        while (es != 59) do_tick(1'b1);
        check_time("R4 at 09:59:59");
        do_tick(1'b1);
        check_time("R4 hours tens step");
    endtask

    task automatic t_mid_reset();
        for (int i = 0; i < 3; i++) do_tick(1'b1);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        eh = 0; em = 0; es = 0;
        check_time("R1 mid-run reset");
    endtask

    initial begin
        rst = 1'b1; tick_1hz = 1'b0; set_mode = 1'b0;
        min_set = 1'b0; hr_set = 1'b0;
        t_reset();
        t_seconds();
        t_run_buttons();
        t_set_hold();
        t_set_minutes();
        t_set_hours();
        t_full_roll();
        t_hour_tens();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks, fails);
            $finish;
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks, fails);
            $finish;
        end
    end
endmodule